// File: doc/BRIEF.md
# Arithmetic Unit with Flag Generation and Condition Evaluation

This block is the purely combinational execute stage of a small 64-bit integer datapath. An arithmetic/logic core applies one of four operations to two operands and, from the same operands and the result, derives a three-bit flag set: zero, sign and overflow. Overflow follows a rule specific to each operation. Subtraction takes the first operand away from the second.

A separate condition evaluator sits beside the core. It reads a flag set that the enclosing datapath stored earlier and a four-bit condition selector. It returns one bit that serves two purposes: it decides whether a conditional branch is taken, and whether a conditional register move is allowed to write. The evaluator never looks at the flags being computed in the current cycle. The flag register, its write enable and all sequencing belong to the surrounding datapath.

Top module: `alu_cond_unit`

## Requirements
- R1: Function code 0 returns the 64-bit sum of operand A and operand B, wrapping modulo 2^64.
- R2: Function code 1 returns operand B minus operand A, wrapping modulo 2^64.
- R3: Function code 2 returns A AND B, and function code 3 returns A XOR B.
- R4: Every function code from 4 to 15 returns a zero result, with flag outputs Z=1, S=0, O=0.
- R5: The zero flag is 1 exactly when the result is all zeros.
- R6: The sign flag equals bit 63 of the result.
- R7: On add, overflow is 1 when A and B share a sign bit and the result's sign bit differs from A's.
- R8: On subtract, overflow is 1 when A and B have different sign bits and the result's sign bit differs from B's.
- R9: On AND, XOR and unknown codes, overflow is 0.
- R10: The flag outputs and the stored flag input both use the packing Z in bit 2, S in bit 1 and O in bit 0.
- R11: With stored flags Z, S, O, the condition output is: selector 0 always 1; 1 (S^O)|Z; 2 S^O; 3 Z; 4 !Z; 5 !(S^O); 6 !(S^O)&!Z.
- R12: Condition selectors 7 to 15 return 0 for every stored flag value.
- R13: The condition output depends only on the stored flag input and the selector, never on the flags being produced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_sel | input | 4 | Operation selector (0 add, 1 subtract, 2 AND, 3 XOR) |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| flags_held | input | 3 | Stored flags {Z,S,O} from the datapath register |
| cond_sel | input | 4 | Condition selector |
| result | output | 64 | Operation result |
| flags_new | output | 3 | Freshly computed flags {Z,S,O} |
| cond_true | output | 1 | Branch-taken / move-enable bit |

## Verification
The ALU producing new flags and the evaluator judging a condition happen in the same cycle. A datapath that wrongly routed the fresh flags into the evaluator would look correct whenever the two flag sets agree. The bench therefore applies operations whose new flags contradict the stored flag input, for example a zero-producing subtract against stored flags with Z clear. It then checks that the condition bit follows only the stored value, while the new flags still reflect the operation.

// File: rtl/alucc_pkg.sv
package alucc_pkg;
  localparam int unsigned FN_W   = 4;
  localparam int unsigned COND_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [COND_W-1:0] {
    CD_ALWAYS = 4'd0,
    CD_LE     = 4'd1,
    CD_LT     = 4'd2,
    CD_EQ     = 4'd3,
    CD_NE     = 4'd4,
    CD_GE     = 4'd5,
    CD_GT     = 4'd6
  } cond_e;

  // bit 2 = zero, bit 1 = sign, bit 0 = overflow
  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alucc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [FN_W-1:0] fn,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res
);
  always_comb begin
    unique case (fn)
      FN_ADD:  res = a + b;
      FN_SUB:  res = b - a;
      FN_AND:  res = a & b;
      FN_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_SUB) begin
      // R2
      sub_inverse_chk: assert (res + a == b);
    end
    if (fn == FN_AND) begin
      // R3
      and_subset_chk: assert ((res & ~a) == '0 && (res & ~b) == '0);
    end
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import alucc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [FN_W-1:0] fn,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    res,
  output flags_t          flags
);
  localparam int unsigned MSB = W - 1;

  logic sa, sb, sr;
  assign sa = a[MSB];
  assign sb = b[MSB];
  assign sr = res[MSB];

  always_comb begin
    flags.z = (res == '0);
    flags.s = sr;
    unique case (fn)
      FN_ADD:  flags.o = (sa == sb) && (sr != sa);
      FN_SUB:  flags.o = (sa != sb) && (sr != sb);
      default: flags.o = 1'b0;
    endcase
  end

  always_comb begin
    if (fn == FN_ADD && flags.o) begin
      // R7
      add_ovf_sign_chk: assert (res[MSB] != a[MSB] && a[MSB] == b[MSB]);
    end
    if (fn == FN_SUB && flags.o) begin
      // R8
      sub_ovf_sign_chk: assert (a[MSB] != b[MSB] && res[MSB] != b[MSB]);
    end
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alucc_pkg::*;
(
  input  flags_t            held,
  input  logic [COND_W-1:0] sel,
  output logic              hit
);
  logic lt;
  assign lt = held.s ^ held.o;

  always_comb begin
    unique case (sel)
      CD_ALWAYS: hit = 1'b1;
      CD_LE:     hit = lt | held.z;
      CD_LT:     hit = lt;
      CD_EQ:     hit = held.z;
      CD_NE:     hit = ~held.z;
      CD_GE:     hit = ~lt;
      CD_GT:     hit = ~lt & ~held.z;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    if (sel == CD_GT && hit) begin
      // R11
      gt_excludes_zero_chk: assert (!held.z && (held.s == held.o));
    end
    if (sel == CD_LE && !hit) begin
      // R11
      le_false_needs_nonzero_chk: assert (!held.z);
    end
  end
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alucc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [3:0]   fn_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   flags_held,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] result,
  output logic [2:0]   flags_new,
  output logic         cond_true
);
  flags_t fl_out;
  flags_t fl_in;

  assign fl_in = flags_t'(flags_held);

  alu_core #(.W(W)) u_core (
    .fn  (fn_sel),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (result)
  );

  flag_gen #(.W(W)) u_flags (
    .fn    (fn_sel),
    .a     (opnd_a),
    .b     (opnd_b),
    .res   (result),
    .flags (fl_out)
  );

  cond_eval u_cond (
    .held (fl_in),
    .sel  (cond_sel),
    .hit  (cond_true)
  );

  assign flags_new = fl_out;

  always_comb begin
    if (fn_sel > 4'd3) begin
      // R4
      unknown_fn_chk: assert (result == '0 && flags_new == 3'b100);
    end
    if (cond_sel > 4'd6) begin
      // R12
      unknown_cond_chk: assert (!cond_true);
    end
  end
endmodule

// File: tb/test_alu_cond_unit.sv
module test_alu_cond_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [3:0]  fn_sel;
  logic [63:0] opnd_a, opnd_b;
  logic [2:0]  flags_held;
  logic [3:0]  cond_sel;
  logic [63:0] result;
  logic [2:0]  flags_new;
  logic        cond_true;

  int total = 0;
  int bad   = 0;

  alu_cond_unit i_alu_cond_unit (
    .fn_sel(fn_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flags_held(flags_held), .cond_sel(cond_sel),
    .result(result), .flags_new(flags_new), .cond_true(cond_true)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_cond(input logic [2:0] f, input logic [3:0] c);
    logic z, s, o;
    z = f[2]; s = f[1]; o = f[0];
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s result act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkf(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s flags act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chkb(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cond act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] f, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    fn_sel = f; opnd_a = a; opnd_b = b;
    #1;
  endtask

  task automatic t_idle;
    @(negedge clk);
    fn_sel = 0; opnd_a = 0; opnd_b = 0; flags_held = 0; cond_sel = 0;
    #1;
    chk64("R1", result, 64'd0);
    chkf("R5", flags_new, 3'b100);
    chkb("R11", cond_true, 1'b1);
  endtask

  task automatic t_add;
    apply(4'd0, 64'd7, 64'd5);
    chk64("R1", result, 64'd12);
    chkf("R10", flags_new, 3'b000);
    apply(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
    chk64("R1", result, 64'hFFFF_FFFF_FFFF_FFFE);
    chkf("R7", flags_new, 3'b011);
    apply(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    chk64("R1", result, 64'd0);
    chkf("R5", flags_new, 3'b100);
    apply(4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    chkf("R7", flags_new, 3'b101);
  endtask

  task automatic t_sub;
    apply(4'd1, 64'd3, 64'd10);
    chk64("R2", result, 64'd7);
    chkf("R8", flags_new, 3'b000);
    apply(4'd1, 64'd10, 64'd3);
    chk64("R2", result, 64'hFFFF_FFFF_FFFF_FFF9);
    chkf("R6", flags_new, 3'b010);
    apply(4'd1, 64'd1, 64'h8000_0000_0000_0000);
    chk64("R2", result, 64'h7FFF_FFFF_FFFF_FFFF);
    chkf("R8", flags_new, 3'b001);
    apply(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
    chkf("R8", flags_new, 3'b011);
    apply(4'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    chkf("R8", flags_new, 3'b010);
  endtask

  task automatic t_logic;
    apply(4'd2, 64'hF0F0_0000_FFFF_0001, 64'hFF00_FF00_8000_0001);
    chk64("R3", result, 64'hF000_0000_8000_0001);
    chkf("R9", flags_new, 3'b010);
    apply(4'd3, 64'h8000_0000_0000_00FF, 64'h0000_0000_0000_00FF);
    chk64("R3", result, 64'h8000_0000_0000_0000);
    chkf("R9", flags_new, 3'b010);
    apply(4'd3, 64'h1234, 64'h1234);
    chkf("R9", flags_new, 3'b100);
  endtask

  task automatic t_unknown_fn;
    for (int f = 4; f < 16; f++) begin
      apply(4'(f), 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001);
      chk64("R4", result, 64'd0);
      chkf("R4", flags_new, 3'b100);
    end
  endtask

  task automatic t_cond_table;
    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        flags_held = 3'(f); cond_sel = 4'(c);
        #1;
        if (c > 6) chkb("R12", cond_true, 1'b0);
        else       chkb("R11", cond_true, ref_cond(3'(f), 4'(c)));
      end
    end
  endtask

  task automatic t_same_cycle;
    // R13: new flags say zero, stored flags say nonzero
    @(negedge clk);
    flags_held = 3'b000; cond_sel = 4'd3;
    fn_sel = 4'd1; opnd_a = 64'd9; opnd_b = 64'd9;
    #1;
    chkf("R13", flags_new, 3'b100);
    chkb("R13", cond_true, 1'b0);
    @(negedge clk);
    flags_held = 3'b100; cond_sel = 4'd4;
    fn_sel = 4'd0; opnd_a = 64'd1; opnd_b = 64'd1;
    #1;
    chkf("R13", flags_new, 3'b000);
    chkb("R13", cond_true, 1'b0);
    @(negedge clk);
    flags_held = 3'b010; cond_sel = 4'd6;
    fn_sel = 4'd0; opnd_a = 64'd2; opnd_b = 64'd3;
    #1;
    chkb("R13", cond_true, 1'b0);
  endtask

  initial begin
    fn_sel = 0; opnd_a = 0; opnd_b = 0; flags_held = 0; cond_sel = 0;
    repeat (2) @(negedge clk);
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_unknown_fn();
    t_cond_table();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule